// File: doc/BRIEF.md
# Ambient Light Threshold Interrupt Controller

This block watches the stream of finished channel-0 conversions from a light sensor's ADC and decides when software should be told about them. Each 16-bit result is compared against a programmable window bounded by a low and a high limit. A persistence filter then requires a chosen number of consecutive out-of-window results before an interrupt is raised. With a persistence of zero, every conversion raises one.

Configuration arrives as abstract byte-wide register writes, for the two limits and one interrupt control byte. Clearing arrives as a command byte on a separate strobe. Once raised, the interrupt stays pending until a clear command arrives. The pending state is shown on a level line in level and test modes. In alert mode it is shown as a one-cycle request pulse. The bus interface, integration timing and lux arithmetic live elsewhere.

Top module: `lux_thresh_irq`

## Requirements
- R1: After reset both limits and the control byte are zero (mode off), nothing is pending, and `irq_level` and `alert_pulse` are low.
- R2: Byte writes go to fixed addresses: 0x2 low limit bits [7:0], 0x3 low limit bits [15:8], 0x4 high limit bits [7:0], 0x5 high limit bits [15:8], 0x6 control byte. Writes to any other address change no limit and no control state.
- R3: A sample is out of window only when it is strictly below the low limit or strictly above the high limit. A sample equal to either limit counts as in window.
- R4: With control bits [1:0] nonzero and persistence (control bits [7:4]) equal to 0, every sample strobe makes the interrupt pending one cycle later, whatever its value.
- R5: With persistence N (1..15), the interrupt becomes pending one cycle after the Nth consecutive out-of-window sample. An in-window sample resets the run to zero, and the run also restarts from zero after each firing.
- R6: In level mode (control bits [1:0] = 1), `irq_level` is high whenever an interrupt is pending and stays high until cleared.
- R7: A command byte with bit 7 and bit 6 both set clears the pending interrupt one cycle later. A command byte with only one of those bits set has no effect.
- R8: In alert mode (bits [1:0] = 2), `irq_level` stays low. `alert_pulse` is high for exactly one cycle when the interrupt goes from not pending to pending, and does not pulse for a trigger while already pending.
- R9: Writing the control byte with bits [1:0] = 3 (test mode) makes the interrupt pending on the next cycle without any sample, shown on `irq_level`. In test mode, samples are filtered as in level mode.
- R10: Any control byte write resets the consecutive run to zero. A sample strobed in the same cycle as a control write is not counted.
- R11: When a trigger and a clear command occur in the same cycle, the interrupt is pending afterwards.
- R12: With bits [1:0] = 0, samples never make an interrupt pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register byte write strobe |
| wr_addr | input | 4 | Register address of the write |
| wr_data | input | 8 | Register write data |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte; bits 7 and 6 together request a clear |
| smp_valid | input | 1 | Conversion-complete strobe |
| smp_data | input | 16 | Channel-0 conversion result |
| irq_level | output | 1 | Level interrupt in level and test modes |
| alert_pulse | output | 1 | One-cycle alert request in alert mode |

## Verification
A wrong run counter shows at the ports as an interrupt that fires one or more samples too early or too late. The persistence scenarios place an in-window sample in the middle of a run and a control write inside a run, so an off-by-one count or a missed reset appears within one sample of the expected firing. A stuck or wrongly masked pending flag shows on `irq_level` or `alert_pulse` on the cycle after the clear or trigger. The reference model is compared on every clock, so such a fault is caught on its first cycle. Limit-register decode faults appear as a wrong firing decision on the first sample whose value lies exactly at, or just beyond, a limit.

// File: rtl/lti_pkg.sv
// Shared definitions for the light threshold interrupt controller.
// Assumes the control byte holds the mode in [1:0] and persistence in [7:4].
package lti_pkg;
    typedef enum logic [1:0] {
        IRQ_OFF   = 2'd0,
        IRQ_LEVEL = 2'd1,
        IRQ_ALERT = 2'd2,
        IRQ_TEST  = 2'd3
    } irq_mode_e;

    localparam int MODE_LSB    = 0;
    localparam int PERSIST_LSB = 4;
    localparam int PERSIST_W   = 4;
endpackage

// File: rtl/lti_regs.sv
// Limit and control register file.
// Holds the two DATA_W-wide window limits, each written one byte at a time
// from THR_BASE upward (low limit bytes first), and the control byte at the
// address just above them. Assumes DATA_W is a multiple of 8.
module lti_regs #(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 4,
    parameter int THR_BASE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [DATA_W-1:0] thr_lo,
    output logic [DATA_W-1:0] thr_hi,
    output logic [7:0]        ctrl_q,
    output logic              ctrl_wr
);
    localparam int NBYTES    = DATA_W / 8;
    localparam int NSLOTS    = 2 * NBYTES;
    localparam int CTRL_ADDR = THR_BASE + NSLOTS;

    logic [NSLOTS-1:0]   byte_hit;
    logic [2*DATA_W-1:0] thr_flat;

    // One decode per limit byte slot.
    for (genvar i = 0; i < NSLOTS; i++) begin : g_hit
        assign byte_hit[i] = wr_en && (wr_addr == ADDR_W'(THR_BASE + i));
    end

    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    assign thr_lo  = thr_flat[DATA_W-1:0];
    assign thr_hi  = thr_flat[2*DATA_W-1:DATA_W];

    // Limit byte storage, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_flat <= '0;
        end else begin
            for (int i = 0; i < NSLOTS; i++) begin
                if (byte_hit[i]) thr_flat[i*8 +: 8] <= wr_data;
            end
        end
    end

    // Control byte storage, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wr_data;
    end

    // R2: the control byte changes only on a write to its own address.
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl_q));

    // R2: limits hold when no limit slot is addressed.
    p_thr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_hit == '0) |=> $stable(thr_flat));
endmodule

// File: rtl/lti_persist.sv
// Window comparison and persistence filter.
// Counts consecutive out-of-window samples and raises fire for one cycle
// when the run reaches the persistence value; persistence 0 fires on every
// sample. A control write clears the run and the sample in that cycle is
// dropped. Assumes the mode and persistence inputs come from registers.
module lti_persist
    import lti_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [DATA_W-1:0]    smp_data,
    input  logic [DATA_W-1:0]    thr_lo,
    input  logic [DATA_W-1:0]    thr_hi,
    input  irq_mode_e            mode,
    input  logic [PERSIST_W-1:0] persist,
    input  logic                 ctrl_wr,
    output logic                 fire
);
    logic [PERSIST_W-1:0] run_q, run_d;
    logic [PERSIST_W:0]   run_inc;
    logic                 outside;

    assign outside = (smp_data < thr_lo) || (smp_data > thr_hi);
    assign run_inc = {1'b0, run_q} + 1'b1;

    // Next run length and firing decision.
    always_comb begin
        run_d = run_q;
        fire  = 1'b0;
        if (ctrl_wr) begin
            run_d = '0;
        end else if (smp_valid && (mode != IRQ_OFF)) begin
            if (persist == '0) begin
                fire = 1'b1;
            end else if (outside) begin
                if (run_inc >= {1'b0, persist}) begin
                    fire  = 1'b1;
                    run_d = '0;
                end else begin
                    run_d = run_inc[PERSIST_W-1:0];
                end
            end else begin
                run_d = '0;
            end
        end
    end

    // Run length register.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // R5: the run never reaches the persistence value without firing.
    p_run_below_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (persist != '0) |-> (run_q < persist));

    // R3: a sample on either limit of a valid window ends the run.
    p_edge_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !ctrl_wr && (mode != IRQ_OFF) && (persist != '0)
         && (thr_lo <= thr_hi) && ((smp_data == thr_lo) || (smp_data == thr_hi)))
        |=> (run_q == '0));

    // R10: a control write leaves the run at zero.
    p_ctrl_clears_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (run_q == '0));
endmodule

// File: rtl/lux_thresh_irq.sv
// Light sensor threshold interrupt controller, top level.
// Combines the register file and the persistence filter with the pending
// flag, the clear command decode and the output shaping per mode.
// Assumes all inputs are synchronous to clk.
module lux_thresh_irq
    import lti_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              irq_level,
    output logic              alert_pulse
);
    localparam int CMD_SEL_BIT = 7;
    localparam int CMD_CLR_BIT = 6;

    logic [DATA_W-1:0]    thr_lo, thr_hi;
    logic [7:0]           ctrl_q;
    logic                 ctrl_wr;
    logic                 fire;
    irq_mode_e            mode, mode_next;
    logic [PERSIST_W-1:0] persist;
    logic                 test_set, set_req, clr_req;
    logic                 pending_q;
    logic                 alert_q;

    lti_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .thr_lo  (thr_lo),
        .thr_hi  (thr_hi),
        .ctrl_q  (ctrl_q),
        .ctrl_wr (ctrl_wr)
    );

    assign mode      = irq_mode_e'(ctrl_q[MODE_LSB +: 2]);
    assign persist   = ctrl_q[PERSIST_LSB +: PERSIST_W];
    assign mode_next = ctrl_wr ? irq_mode_e'(wr_data[MODE_LSB +: 2]) : mode;

    lti_persist #(.DATA_W(DATA_W)) filt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .mode      (mode),
        .persist   (persist),
        .ctrl_wr   (ctrl_wr),
        .fire      (fire)
    );

    assign test_set = ctrl_wr && (irq_mode_e'(wr_data[MODE_LSB +: 2]) == IRQ_TEST);
    assign set_req  = fire || test_set;
    assign clr_req  = cmd_valid && cmd_byte[CMD_SEL_BIT] && cmd_byte[CMD_CLR_BIT];

    // Pending flag: a trigger takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending_q <= 1'b0;
        else if (set_req) pending_q <= 1'b1;
        else if (clr_req) pending_q <= 1'b0;
    end

    // Alert request: one cycle on a new pending event in alert mode.
    always_ff @(posedge clk) begin
        if (!rst_n) alert_q <= 1'b0;
        else        alert_q <= set_req && !pending_q && (mode_next == IRQ_ALERT);
    end

    assign irq_level   = pending_q && ((mode == IRQ_LEVEL) || (mode == IRQ_TEST));
    assign alert_pulse = alert_q;

    // R4: persistence zero turns every enabled sample into a pending interrupt.
    p_every_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !ctrl_wr && (mode != IRQ_OFF) && (persist == '0)) |=> pending_q);

    // R7: a clear with no trigger drops the pending flag.
    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> !pending_q);

    // R6: without a clear command, a pending interrupt stays pending.
    p_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !clr_req) |=> pending_q);

    // R8: the alert request lasts one cycle and coincides with a new pending flag.
    p_alert_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alert_pulse |=> !alert_pulse);
    p_alert_new_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alert_pulse |-> (pending_q && $rose(pending_q)));

    // R9: a test-mode control write sets the pending flag at once.
    p_test_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        test_set |=> irq_level);

    // R11: trigger and clear together leave the interrupt pending.
    p_trigger_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && clr_req) |=> pending_q);

    // R12: with the mode off, the filter never fires.
    p_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == IRQ_OFF && !ctrl_wr) |-> !fire);
endmodule

// File: tb/lux_thresh_irq_tb_top.sv
// Bench for lux_thresh_irq: a behavioural reference model compared every clock,
// plus targeted checks after each scenario step.
`timescale 1ns/1ps
module lux_thresh_irq_tb_top;
    localparam int WD_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        irq_level;
    logic        alert_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit model_on = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    lux_thresh_irq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cmd_valid   (cmd_valid),
        .cmd_byte    (cmd_byte),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .irq_level   (irq_level),
        .alert_pulse (alert_pulse)
    );

    // Reference model state.
    int m_lo, m_hi, m_ctrl, m_run;
    bit m_pend, m_alert;

    function automatic bit m_irq();
        int md = m_ctrl & 3;
        return m_pend && (md == 1 || md == 3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_ctrl = 0; m_run = 0; m_pend = 0; m_alert = 0;
        end else begin
            int md, per, nmd;
            bit trig, clr, cw;
            md   = m_ctrl & 3;
            per  = (m_ctrl >> 4) & 15;
            cw   = wr_en && wr_addr == 4'd6;
            nmd  = cw ? int'(wr_data) & 3 : md;
            trig = 0;
            if (cw) begin
                m_run = 0;
                if ((int'(wr_data) & 3) == 3) trig = 1;
            end else if (smp_valid && md != 0) begin
                if (per == 0) trig = 1;
                else if (int'(smp_data) < m_lo || int'(smp_data) > m_hi) begin
                    m_run++;
                    if (m_run >= per) begin trig = 1; m_run = 0; end
                end else m_run = 0;
            end
            clr = cmd_valid && cmd_byte[7] && cmd_byte[6];
            m_alert = trig && !m_pend && nmd == 2;
            if (trig) m_pend = 1; else if (clr) m_pend = 0;
            if (wr_en) begin
                case (wr_addr)
                    4'd2: m_lo = (m_lo & 'hFF00) | int'(wr_data);
                    4'd3: m_lo = (m_lo & 'h00FF) | (int'(wr_data) << 8);
                    4'd4: m_hi = (m_hi & 'hFF00) | int'(wr_data);
                    4'd5: m_hi = (m_hi & 'h00FF) | (int'(wr_data) << 8);
                    4'd6: m_ctrl = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (model_on && !done) begin
            chk(irq_level == m_irq(), cur_req, irq_level, m_irq(), "model irq_level");
            chk(alert_pulse == m_alert, cur_req, alert_pulse, m_alert, "model alert_pulse");
        end
    end

    task automatic cyc();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic smp(input logic [15:0] v);
        smp_valid = 1'b1; smp_data = v;
        cyc();
        smp_valid = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);
        cmd_valid = 1'b1; cmd_byte = b;
        cyc();
        cmd_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
            finish_run();
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        model_on = 1'b1;

        cur_req = "R1";
        chk(irq_level == 0, "R1", irq_level, 0, "irq after reset");
        chk(alert_pulse == 0, "R1", alert_pulse, 0, "alert after reset");
        smp(16'h0000);
        chk(irq_level == 0, "R1", irq_level, 0, "sample with reset control");

        cur_req = "R2";
        wr(4'd2, 8'h00); wr(4'd3, 8'h01); wr(4'd4, 8'h00); wr(4'd5, 8'h0F);

        cur_req = "R4";
        wr(4'd6, 8'h01);
        smp(16'h0500);
        chk(irq_level == 1, "R4", irq_level, 1, "in-window sample with persistence 0");

        cur_req = "R7";
        cmd(8'h80);
        chk(irq_level == 1, "R7", irq_level, 1, "select bit only");
        cmd(8'h40);
        chk(irq_level == 1, "R7", irq_level, 1, "clear bit only");
        cur_req = "R6";
        repeat (3) cyc();
        chk(irq_level == 1, "R6", irq_level, 1, "level held");
        cur_req = "R7";
        cmd(8'hC0);
        chk(irq_level == 0, "R7", irq_level, 0, "clear command");

        cur_req = "R5";
        wr(4'd6, 8'h31);
        smp(16'h0050); smp(16'h2000); smp(16'h0500);
        smp(16'h0050); smp(16'h0050);
        chk(irq_level == 0, "R5", irq_level, 0, "run broken by in-window sample");
        smp(16'h0F01);
        chk(irq_level == 1, "R5", irq_level, 1, "third consecutive outside");
        cmd(8'hC0);
        smp(16'hFFFF);
        chk(irq_level == 0, "R5", irq_level, 0, "run restarts after firing");
        smp(16'h0500);

        cur_req = "R3";
        wr(4'd6, 8'h11);
        smp(16'h0100);
        chk(irq_level == 0, "R3", irq_level, 0, "equal to low limit");
        smp(16'h0F00);
        chk(irq_level == 0, "R3", irq_level, 0, "equal to high limit");
        smp(16'h00FF);
        chk(irq_level == 1, "R3", irq_level, 1, "one below low limit");
        cmd(8'hC0);
        smp(16'h0F01);
        chk(irq_level == 1, "R3", irq_level, 1, "one above high limit");
        cmd(8'hC0);

        cur_req = "R2";
        wr(4'd0, 8'hFF); wr(4'd7, 8'hFF); wr(4'd1, 8'hFF); wr(4'd15, 8'hFF);
        smp(16'h00FF);
        chk(irq_level == 1, "R2", irq_level, 1, "low limit kept after stray writes");
        cmd(8'hC0);
        smp(16'h0F00);
        chk(irq_level == 0, "R2", irq_level, 0, "high limit kept after stray writes");

        cur_req = "R10";
        wr(4'd6, 8'h21);
        smp(16'h0001);
        wr(4'd6, 8'h21);
        smp(16'h0001);
        chk(irq_level == 0, "R10", irq_level, 0, "run reset by control write");
        wr_en = 1'b1; wr_addr = 4'd6; wr_data = 8'h21; smp_valid = 1'b1; smp_data = 16'h0001;
        cyc();
        wr_en = 1'b0; smp_valid = 1'b0;
        smp(16'h0001);
        chk(irq_level == 0, "R10", irq_level, 0, "sample with control write dropped");
        smp(16'h0001);
        chk(irq_level == 1, "R10", irq_level, 1, "fires after two counted samples");
        cmd(8'hC0);

        cur_req = "R8";
        wr(4'd6, 8'h12);
        smp(16'hF000);
        chk(alert_pulse == 1, "R8", alert_pulse, 1, "alert on new event");
        chk(irq_level == 0, "R8", irq_level, 0, "level masked in alert mode");
        cyc();
        chk(alert_pulse == 0, "R8", alert_pulse, 0, "alert lasts one cycle");
        smp(16'hF000);
        chk(alert_pulse == 0, "R8", alert_pulse, 0, "no alert while pending");
        cmd(8'hC0);
        smp(16'hF000);
        chk(alert_pulse == 1, "R8", alert_pulse, 1, "alert after clear");
        cmd(8'hC0);

        cur_req = "R9";
        wr(4'd6, 8'h03);
        chk(irq_level == 1, "R9", irq_level, 1, "test mode write");
        cmd(8'hC0);
        chk(irq_level == 0, "R9", irq_level, 0, "test interrupt cleared");

        cur_req = "R11";
        smp_valid = 1'b1; smp_data = 16'h0500; cmd_valid = 1'b1; cmd_byte = 8'hC0;
        cyc();
        smp_valid = 1'b0; cmd_valid = 1'b0;
        chk(irq_level == 1, "R11", irq_level, 1, "trigger beats clear");
        cmd(8'hC0);

        cur_req = "R12";
        wr(4'd6, 8'h00);
        smp(16'h0000); smp(16'hFFFF);
        chk(irq_level == 0, "R12", irq_level, 0, "mode off, persistence 0");
        chk(alert_pulse == 0, "R12", alert_pulse, 0, "mode off, no alert");
        wr(4'd6, 8'hF0);
        smp(16'h0000);
        chk(irq_level == 0, "R12", irq_level, 0, "mode off, persistence 15");

        repeat (2) cyc();
        finish_run();
    end
endmodule